// File: doc/BRIEF.md
# Four-Stage Expiry Watchdog with Tick Timer

This block is a register-mapped watchdog peripheral. A periodic tick timer divides a 1 MHz reference enable into ticks; for example, a reload value of 250000 gives one tick every quarter second. A watchdog counter counts those ticks down from a programmable period. Each time the countdown runs out, the watchdog reloads the period and advances a two-bit expiry stage. The fourth run-out raises a one-cycle system reset pulse and halts the watchdog.

Software starts or restarts the countdown through a command register. Through a status register it reads the remaining count and the expiry stage. The time left before reset, in ticks, is (3 - stage) x period + count. Stopping the watchdog needs a key written to an unlock register just before the stop command. An interrupt level can be raised on each expiry.

Writes use a one-cycle write strobe. Reads use a separate read address, and the read data follows that address combinationally.

Top module: `stg_wdog`

## Requirements
- R1: After reset, irq_o and sys_rst_o are 0 and every register reads 0. The registers are configuration 0x00, status 0x04, command 0x08, unlock 0x0C and timer control 0x10.
- R2: Timer control layout: bits 29:0 hold the reload value N, bit 31 enables the timer, bit 30 selects periodic mode. With periodic mode on, a tick is produced on every N-th ref_tick pulse, counted from the last write to timer control.
- R3: With bit 30 clear (one-shot mode), the timer produces one tick and then clears its own enable bit (bit 31), which reads back as 0.
- R4: Configuration layout: bits 3:0 select the timer, bits 11:4 hold the period P (a value of 0 acts as 1), bit 12 enables the interrupt, bit 15 enables the reset output. Writing command bit 0 loads the countdown with P and clears the stage. Status then reads the count in bits 11:4 and the stage in bits 13:12.
- R5: Each tick while running lowers the count by one. A tick that arrives at count 1 is an expiry: the count reloads to P and the stage goes up by one.
- R6: At the expiry that happens while the stage is 3, the stage stays at 3, the count reloads, counting stops, and sys_rst_o pulses high for exactly one cycle if reset is enabled.
- R7: With the reset-enable bit clear, the fourth expiry produces no sys_rst_o pulse.
- R8: irq_o is a sticky level. It is set by any expiry that happens while the interrupt is enabled, and it is cleared by a start command or by an accepted stop.
- R9: A stop command (command bit 1) is ignored unless the last write before it was the value 0xC45A to the unlock register. Any command write uses up the unlock.
- R10: An unlocked stop halts the countdown, holds the status value and clears irq_o. If both command bits are set, the stop wins.
- R11: Ticks reach the countdown only when the configuration's timer-select field equals the parameter TMR_ID (default 5).
- R12: Writing 0 to timer control stops tick generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable from the 1 MHz reference |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_o | output | 1 | Sticky expiry interrupt |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
A wrong stage or count shows up in the status word on the first read after the tick that corrupted it. It also shows up at the pins as a reset pulse one expiry early or late, that is, a whole period of ticks away from the expected place. A wrong unlock state shows on the next tick after a stop command: the count either keeps moving when it should hold, or holds when it should move. Tick pacing faults show within N reference pulses as a count that moves early or late.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int PER_W  = 8;
    localparam int STG_W  = 2;
    localparam int SEL_W  = 4;
    localparam int RLD_W  = 30;

    localparam logic [ADDR_W-1:0] A_CFG = 5'h00;
    localparam logic [ADDR_W-1:0] A_STS = 5'h04;
    localparam logic [ADDR_W-1:0] A_CMD = 5'h08;
    localparam logic [ADDR_W-1:0] A_KEY = 5'h0C;
    localparam logic [ADDR_W-1:0] A_TMR = 5'h10;

    localparam logic [15:0] UNLOCK_KEY = 16'hC45A;
    localparam logic [STG_W-1:0] LAST_STG = '1;

    typedef struct packed {
        logic             rst_en;
        logic             irq_en;
        logic [PER_W-1:0] period;
        logic [SEL_W-1:0] sel;
    } wd_cfg_t;

    typedef struct packed {
        logic             en;
        logic             periodic;
        logic [RLD_W-1:0] reload;
    } tmr_ctl_t;

    typedef enum logic [1:0] {WD_OFF, WD_COUNT, WD_TRIPPED} wd_state_e;

    function automatic logic [PER_W-1:0] eff_period(input logic [PER_W-1:0] p);
        return (p == '0) ? PER_W'(1) : p;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input wd_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SEL_W-1:0] = c.sel;
        w[4 +: PER_W] = c.period;
        w[12] = c.irq_en;
        w[15] = c.rst_en;
        return w;
    endfunction

    function automatic wd_cfg_t cfg_decode(input logic [DATA_W-1:0] w);
        wd_cfg_t c;
        c.sel    = w[SEL_W-1:0];
        c.period = w[4 +: PER_W];
        c.irq_en = w[12];
        c.rst_en = w[15];
        return c;
    endfunction
endpackage

// File: rtl/wdg_tick_timer.sv
module wdg_tick_timer
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output tmr_ctl_t          ctl_q,
    output logic              tick
);
    logic [RLD_W-1:0] acc_q;
    logic             live;
    logic             last;

    assign live = ctl_q.en && ref_tick && (ctl_q.reload != '0);
    assign last = (acc_q == ctl_q.reload - RLD_W'(1));
    assign tick = live && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            acc_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= tmr_ctl_t'(ctl_wdata);
            acc_q <= '0;
        end else if (live) begin
            if (last) begin
                acc_q <= '0;
                if (!ctl_q.periodic) ctl_q.en <= 1'b0;
            end else begin
                acc_q <= acc_q + RLD_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic [PER_W-1:0] period,
    input  logic             irq_en,
    input  logic             rst_en,
    output logic [PER_W-1:0] count,
    output logic [STG_W-1:0] stage,
    output logic             running,
    output logic             irq,
    output logic             sys_rst
);
    wd_state_e state_q;
    logic      expire;

    assign running = (state_q == WD_COUNT);
    assign expire  = running && tick && (count <= PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_OFF;
            count   <= '0;
            stage   <= '0;
            irq     <= 1'b0;
            sys_rst <= 1'b0;
        end else begin
            sys_rst <= 1'b0;
            if (stop) begin
                state_q <= WD_OFF;
                irq     <= 1'b0;
            end else if (start) begin
                state_q <= WD_COUNT;
                count   <= period;
                stage   <= '0;
                irq     <= 1'b0;
            end else if (expire) begin
                count <= period;
                if (irq_en) irq <= 1'b1;
                if (stage == LAST_STG) begin
                    state_q <= WD_TRIPPED;
                    sys_rst <= rst_en;
                end else begin
                    stage <= stage + STG_W'(1);
                end
            end else if (running && tick) begin
                count <= count - PER_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [PER_W-1:0]  count,
    input  logic [STG_W-1:0]  stage,
    input  tmr_ctl_t          tmr_ctl,
    output wd_cfg_t           cfg_q,
    output logic              tmr_wr,
    output logic              cmd_wr,
    output logic              key_ok,
    output logic              start_cmd,
    output logic              stop_cmd,
    output logic [DATA_W-1:0] rd_data
);
    logic cfg_wr, key_wr;

    assign cfg_wr    = wr_en && (wr_addr == A_CFG);
    assign cmd_wr    = wr_en && (wr_addr == A_CMD);
    assign key_wr    = wr_en && (wr_addr == A_KEY);
    assign tmr_wr    = wr_en && (wr_addr == A_TMR);
    assign stop_cmd  = cmd_wr && wr_data[1] && key_ok;
    assign start_cmd = cmd_wr && wr_data[0] && !stop_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            key_ok <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q <= cfg_decode(wr_data);
            if (key_wr)      key_ok <= (wr_data[15:0] == UNLOCK_KEY);
            else if (wr_en)  key_ok <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CFG: rd_data = cfg_word(cfg_q);
            A_STS: begin
                rd_data[4 +: PER_W]  = count;
                rd_data[12 +: STG_W] = stage;
            end
            A_TMR: rd_data = DATA_W'(tmr_ctl);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/stg_wdog.sv
module stg_wdog
    import wdg_pkg::*;
#(
    parameter int TMR_ID = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o,
    output logic              sys_rst_o
);
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(TMR_ID);

    wd_cfg_t          cfg_q;
    tmr_ctl_t         tmr_ctl;
    logic             tmr_wr, cmd_wr, key_ok, start_cmd, stop_cmd;
    logic             raw_tick, tick, wd_run;
    logic [PER_W-1:0] wd_cnt, per_eff;
    logic [STG_W-1:0] wd_stg;

    assign tick    = raw_tick && (cfg_q.sel == MY_SEL);
    assign per_eff = eff_period(cfg_q.period);

    wdg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .count(wd_cnt), .stage(wd_stg), .tmr_ctl(tmr_ctl),
        .cfg_q(cfg_q), .tmr_wr(tmr_wr), .cmd_wr(cmd_wr), .key_ok(key_ok),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .rd_data(rd_data)
    );

    wdg_tick_timer u_tmr (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .ctl_wr(tmr_wr),
        .ctl_wdata(wr_data), .ctl_q(tmr_ctl), .tick(raw_tick)
    );

    wdg_countdown u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .start(start_cmd), .stop(stop_cmd),
        .period(per_eff), .irq_en(cfg_q.irq_en), .rst_en(cfg_q.rst_en),
        .count(wd_cnt), .stage(wd_stg), .running(wd_run), .irq(irq_o),
        .sys_rst(sys_rst_o)
    );
endmodule

// File: rtl/stg_wdog_chk.sv
module stg_wdog_chk
    import wdg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             start_cmd,
    input logic             cmd_wr,
    input logic             dis_bit,
    input logic             key_ok,
    input logic             wd_run,
    input logic [PER_W-1:0] wd_cnt,
    input logic [STG_W-1:0] wd_stg,
    input logic [PER_W-1:0] per_eff,
    input logic             irq_en,
    input logic             rst_en,
    input logic             irq_o,
    input logic             sys_rst_o
);
    // R6
    rst_single_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |=> !sys_rst_o);
    // R6
    rst_last_stage_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |-> (wd_stg == LAST_STG) && !wd_run && $past(rst_en));
    // R4
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start_cmd |=> (wd_cnt == $past(per_eff)) && (wd_stg == '0) && wd_run);
    // R5
    stage_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_stg != $past(wd_stg)) |-> (wd_stg == $past(wd_stg) + STG_W'(1)) || $past(start_cmd));
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(irq_en));
    // R9
    locked_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && dis_bit && !key_ok && wd_run && !tick) |=> wd_run);
endmodule

bind stg_wdog stg_wdog_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .start_cmd(start_cmd), .cmd_wr(cmd_wr),
    .dis_bit(wr_data[1]), .key_ok(key_ok), .wd_run(wd_run), .wd_cnt(wd_cnt),
    .wd_stg(wd_stg), .per_eff(per_eff), .irq_en(cfg_q.irq_en),
    .rst_en(cfg_q.rst_en), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/sim_stg_wdog.sv
module sim_stg_wdog;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o, sys_rst_o;

    int n_chk = 0;
    int n_bad = 0;
    int pending = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        logic [4:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    stg_wdog u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o),
        .sys_rst_o(sys_rst_o)
    );

    // monitor: pops expected items and compares against the live outputs
    initial begin
        forever begin
            item_t it;
            logic [31:0] got;
            wait (q.size() != 0);
            it = q.pop_front();
            rd_addr = it.addr;
            #1;
            got = (it.kind == 0) ? rd_data : (it.kind == 1) ? 32'(irq_o) : 32'(sys_rst_o);
            n_chk++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
            pending--;
        end
    end

    task automatic expect_item(input int kind, input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
        pending++;
        q.push_back(it);
        wait (pending == 0);
    endtask

    task automatic reg_is(input logic [4:0] a, input logic [31:0] e, input string tag);
        expect_item(0, a, e, tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
        end
    endtask

    function automatic logic [31:0] cfg(input int sel, input int per, input bit ie, input bit re);
        return 32'(sel) | (32'(per) << 4) | (32'(ie) << 12) | (32'(re) << 15);
    endfunction

    localparam logic [31:0] T_EN  = 32'h8000_0000;
    localparam logic [31:0] T_PER = 32'h4000_0000;

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        reg_is(5'h00, 32'h0, "R1 cfg");
        reg_is(5'h04, 32'h0, "R1 status");
        reg_is(5'h10, 32'h0, "R1 timer");
        expect_item(1, 5'h0, 32'h0, "R1 irq");
        expect_item(2, 5'h0, 32'h0, "R1 sysrst");

        // R4 start loads period
        wr(5'h10, T_EN | T_PER | 32'd1);
        wr(5'h00, cfg(5, 3, 1, 1));
        reg_is(5'h00, cfg(5, 3, 1, 1), "R4 cfg readback");
        wr(5'h08, 32'h1);
        reg_is(5'h04, 32'h030, "R4 start load");
        // R5 countdown and expiry
        pulses(1); reg_is(5'h04, 32'h020, "R5 dec");
        pulses(1); reg_is(5'h04, 32'h010, "R5 dec");
        expect_item(1, 5'h0, 32'h0, "R8 irq before expiry");
        pulses(1); reg_is(5'h04, 32'h1030, "R5 expiry stage1");
        expect_item(1, 5'h0, 32'h1, "R8 irq set");
        // R9 stop without unlock ignored
        wr(5'h08, 32'h2);
        pulses(1); reg_is(5'h04, 32'h1020, "R9 locked stop ignored");
        // R9 unlock consumed by other command write
        wr(5'h0C, 32'hC45A);
        wr(5'h08, 32'h0);
        wr(5'h08, 32'h2);
        pulses(1); reg_is(5'h04, 32'h1010, "R9 unlock consumed");
        pulses(1); reg_is(5'h04, 32'h2030, "R5 stage2");
        pulses(3); reg_is(5'h04, 32'h3030, "R5 stage3");
        pulses(2); reg_is(5'h04, 32'h3010, "R6 before last");
        expect_item(2, 5'h0, 32'h0, "R6 no early reset");
        pulses(1);
        expect_item(2, 5'h0, 32'h1, "R6 reset pulse");
        reg_is(5'h04, 32'h3030, "R6 reload on trip");
        @(negedge clk);
        expect_item(2, 5'h0, 32'h0, "R6 single cycle");
        pulses(2); reg_is(5'h04, 32'h3030, "R6 halted");
        expect_item(2, 5'h0, 32'h0, "R6 no repeat");

        // R7 no reset when disabled, R8 start clears irq
        wr(5'h00, cfg(5, 1, 1, 0));
        wr(5'h08, 32'h1);
        expect_item(1, 5'h0, 32'h0, "R8 start clears irq");
        reg_is(5'h04, 32'h010, "R4 restart");
        pulses(3); reg_is(5'h04, 32'h3010, "R5 period1 stages");
        pulses(1);
        expect_item(2, 5'h0, 32'h0, "R7 no reset pulse");
        @(negedge clk);
        expect_item(2, 5'h0, 32'h0, "R7 no reset pulse late");
        expect_item(1, 5'h0, 32'h1, "R8 irq sticky");

        // R10 unlocked stop
        wr(5'h00, cfg(5, 4, 1, 1));
        wr(5'h08, 32'h1);
        pulses(1); reg_is(5'h04, 32'h030, "R10 pre");
        wr(5'h0C, 32'hC45A);
        wr(5'h08, 32'h3);
        pulses(3); reg_is(5'h04, 32'h030, "R10 stopped holds");
        expect_item(1, 5'h0, 32'h0, "R10 irq clear");
        reg_is(5'h0C, 32'h0, "R9 key reads zero");

        // R11 timer select mismatch
        wr(5'h00, cfg(2, 4, 0, 1));
        wr(5'h08, 32'h1);
        pulses(2); reg_is(5'h04, 32'h040, "R11 other timer");

        // R12 timer off
        wr(5'h00, cfg(5, 4, 0, 1));
        wr(5'h08, 32'h1);
        wr(5'h10, 32'h0);
        pulses(2); reg_is(5'h04, 32'h040, "R12 timer zero");
        reg_is(5'h10, 32'h0, "R12 readback");

        // R2 divide by 3
        wr(5'h10, T_EN | T_PER | 32'd3);
        wr(5'h08, 32'h1);
        pulses(2); reg_is(5'h04, 32'h040, "R2 no tick yet");
        pulses(1); reg_is(5'h04, 32'h030, "R2 third pulse");
        pulses(3); reg_is(5'h04, 32'h020, "R2 periodic");

        // R3 one-shot
        wr(5'h10, T_EN | 32'd3);
        wr(5'h08, 32'h1);
        pulses(3); reg_is(5'h04, 32'h030, "R3 one tick");
        reg_is(5'h10, 32'h3, "R3 enable cleared");
        pulses(3); reg_is(5'h04, 32'h030, "R3 no further tick");

        // R4 period zero acts as one
        wr(5'h10, T_EN | T_PER | 32'd1);
        wr(5'h00, cfg(5, 0, 0, 0));
        wr(5'h08, 32'h1);
        reg_is(5'h04, 32'h010, "R4 zero period");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule